// File: doc/BRIEF.md
# Host-Target Mailbox Register Interface

This block is a command mailbox between a processor and a host-side agent. It holds two 64-bit registers: a to-host command word and a from-host reply word. A 32-bit bus reaches each register as a low and a high half. Software loads a command by writing the low half and then the high half of the to-host register. The low-half write only lands when the mailbox is empty. The high-half write completes the command, and the block then decodes it at once.

The completed word carries three fields: a device code in bits 63:56, a command code in bits 55:48 and a 48-bit payload in bits 47:0. The block acts on the command in one of three ways:
- It raises an exit strobe carrying a test exit code.
- It emits a console character on a byte output with a valid strobe.
- It parks a console read request until an input byte arrives.

For every command except the parked read, it writes a reply into the from-host register and empties the to-host register. Console input bytes enter on a byte-valid port and become a reply tagged with the parked request's device and command. Software may also write the from-host register directly. A busy flag stays up between its low-half and high-half writes.

Top module: `host_mailbox`

## Requirements
- R1: After reset both 64-bit registers read as zero, and `exit_valid`, `con_out_valid` and `host_busy` are low.
- R2: A write to the to-host low half (offset 0) is accepted only while the whole to-host register is zero. It loads bits 31:0, clears bits 63:32 and arms the mailbox. A write made while the register is non-zero leaves the register unchanged and disarms it, so a following high-half write has no effect.
- R3: A write to the to-host high half (offset 4) while armed ORs the data into bits 63:32 and processes the completed word. The word is decoded as device = bits 63:56, command = bits 55:48 and payload = bits 47:0. After processing, the to-host register reads zero.
- R4: Device 0, command 0 with payload bit 0 set pulses `exit_valid` for one cycle, with `exit_code` equal to the payload shifted right by one. With payload bit 0 clear there is no pulse. `exit_valid` and `con_out_valid` are never high together.
- R5: Device 1, command 1 pulses `con_out_valid` for one cycle, with `con_out_byte` equal to payload bits 7:0. From-host becomes {bits 63:48 of the word, 48-bit value 0x100 OR the byte}.
- R6: Device 1, command 0 stores the whole word as the pending read request, clears to-host and leaves from-host unchanged.
- R7: A byte on `con_in_byte` with `con_in_valid` sets from-host to {bits 63:48 of the pending request, 0x100 OR the byte}. A byte that arrives in the same cycle as a bus write or command that changes from-host is dropped.
- R8: Every other command, including device 0 command 0 with payload bit 0 clear, sets from-host to {bits 63:48 of the word, 48 zero bits}.
- R9: A write to the from-host low half (offset 8) replaces the register with {32 zero bits, data} and sets `host_busy`. A write to the high half (offset 12) ORs the data into bits 63:32 and clears `host_busy`.
- R10: `bus_rdata` returns the addressed half: offsets 0 and 4 give to-host low and high, and offsets 8 and 12 give from-host low and high. Any other offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed half |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| con_in_valid | input | 1 | Console input byte present |
| con_in_byte | input | 8 | Console input byte |
| con_out_valid | output | 1 | One-cycle strobe for an emitted console byte |
| con_out_byte | output | 8 | Emitted console byte |
| exit_valid | output | 1 | One-cycle strobe reporting a test exit |
| exit_code | output | 47 | Exit code carried with the strobe |
| host_busy | output | 1 | From-host write between low and high halves |

## Verification
The hardest state to reach from the ports is the disarmed mailbox. To get there, the to-host register must be non-zero because a low half has landed without its high half, and then a second low-half write must be rejected. Only after that does the dropped high-half write show up. The bench builds this sequence on purpose and reads both halves back. It also drives a console byte in the same cycle as a from-host write, which checks that the byte is dropped. Finally, it parks a read request before injecting input, so that the tag bits in the reply are seen to come from the stored request.

// File: rtl/host_mailbox_pkg.sv
package host_mailbox_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int DEV_W  = 8;
  localparam int CMD_W  = 8;
  localparam int PAY_W  = WORD_W - DEV_W - CMD_W;
  localparam int TAG_W  = DEV_W + CMD_W;
  localparam int CODE_W = PAY_W - 1;

  localparam logic [DEV_W-1:0] DEV_TEST    = 8'd0;
  localparam logic [DEV_W-1:0] DEV_CONSOLE = 8'd1;
  localparam logic [CMD_W-1:0] CMD_GET     = 8'd0;
  localparam logic [CMD_W-1:0] CMD_PUT     = 8'd1;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_EXIT,
    ACT_PUTC,
    ACT_PARK
  } mbx_act_e;
endpackage

// File: rtl/hmb_addr_dec.sv
module hmb_addr_dec #(
  parameter int ADDR_W   = 5,
  parameter int TO_OFS   = 0,
  parameter int FROM_OFS = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        sel
);
  // sel[0] to-host low, sel[1] to-host high, sel[2] from-host low, sel[3] from-host high
  for (genvar i = 0; i < 4; i++) begin : g_slot
    localparam int BASE = (i < 2) ? TO_OFS : FROM_OFS;
    localparam int OFS  = BASE + 4 * (i % 2);
    assign sel[i] = (addr == OFS[ADDR_W-1:0]);
  end
endmodule

// File: rtl/hmb_cmd_dec.sv
module hmb_cmd_dec
  import host_mailbox_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output mbx_act_e          act,
  output logic [PAY_W-1:0]  reply,
  output logic [CODE_W-1:0] code,
  output logic [7:0]        ch
);
  logic [DEV_W-1:0] dev;
  logic [CMD_W-1:0] cmd;
  logic [PAY_W-1:0] pay;

  assign dev  = word[WORD_W-1 -: DEV_W];
  assign cmd  = word[PAY_W +: CMD_W];
  assign pay  = word[PAY_W-1:0];
  assign code = pay[PAY_W-1:1];
  assign ch   = pay[7:0];

  always_comb begin
    act   = ACT_NONE;
    reply = '0;
    if (dev == DEV_TEST && cmd == CMD_GET) begin
      if (pay[0]) act = ACT_EXIT;
    end else if (dev == DEV_CONSOLE && cmd == CMD_GET) begin
      act = ACT_PARK;
    end else if (dev == DEV_CONSOLE && cmd == CMD_PUT) begin
      act   = ACT_PUTC;
      reply = {{(PAY_W-9){1'b0}}, 1'b1, pay[7:0]};
    end
  end
endmodule

// File: rtl/hmb_regs.sv
module hmb_regs
  import host_mailbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [3:0]        sel,
  input  mbx_act_e          act,
  input  logic [PAY_W-1:0]  reply,
  input  logic [CODE_W-1:0] code,
  input  logic [7:0]        ch,
  input  logic              con_in_valid,
  input  logic [7:0]        con_in_byte,
  output logic [WORD_W-1:0] cand_word,
  output logic [HALF_W-1:0] rdata,
  output logic              exit_valid,
  output logic [CODE_W-1:0] exit_code,
  output logic              con_out_valid,
  output logic [7:0]        con_out_byte,
  output logic              busy
);
  logic [WORD_W-1:0] to_q, to_n, from_q, from_n, pend_q, pend_n;
  logic              allow_q, allow_n, busy_n;
  logic              ex_v_n, co_v_n;
  logic [CODE_W-1:0] code_n;
  logic [7:0]        co_b_n;
  logic              to_en, from_en, pend_en, allow_en, busy_en;
  logic              complete, from_hit;

  assign cand_word = to_q | {wdata, {HALF_W{1'b0}}};
  assign complete  = wr && sel[1] && allow_q;
  assign from_hit  = (wr && (sel[2] || sel[3])) || (complete && act != ACT_PARK);

  always_comb begin
    to_en = 1'b0; from_en = 1'b0; pend_en = 1'b0; allow_en = 1'b0; busy_en = 1'b0;
    to_n = to_q; from_n = from_q; pend_n = pend_q; allow_n = allow_q; busy_n = busy_q_w;
    ex_v_n = 1'b0; co_v_n = 1'b0; code_n = exit_code; co_b_n = con_out_byte;
    if (wr && sel[0]) begin
      allow_en = 1'b1;
      if (to_q == '0) begin
        to_en   = 1'b1;
        to_n    = {{HALF_W{1'b0}}, wdata};
        allow_n = 1'b1;
      end else begin
        allow_n = 1'b0;
      end
    end
    if (complete) begin
      to_en = 1'b1;
      to_n  = '0;
      if (act == ACT_PARK) begin
        pend_en = 1'b1;
        pend_n  = cand_word;
      end else begin
        from_en = 1'b1;
        from_n  = {cand_word[WORD_W-1 -: TAG_W], reply};
      end
      if (act == ACT_EXIT) begin
        ex_v_n = 1'b1;
        code_n = code;
      end
      if (act == ACT_PUTC) begin
        co_v_n = 1'b1;
        co_b_n = ch;
      end
    end
    if (wr && sel[2]) begin
      from_en = 1'b1; busy_en = 1'b1;
      from_n  = {{HALF_W{1'b0}}, wdata};
      busy_n  = 1'b1;
    end
    if (wr && sel[3]) begin
      from_en = 1'b1; busy_en = 1'b1;
      from_n  = from_q | {wdata, {HALF_W{1'b0}}};
      busy_n  = 1'b0;
    end
    if (con_in_valid && !from_hit) begin
      from_en = 1'b1;
      from_n  = {pend_q[WORD_W-1 -: TAG_W], {(PAY_W-9){1'b0}}, 1'b1, con_in_byte};
    end
  end

  logic busy_q_w;
  assign busy = busy_q_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q          <= '0;
      from_q        <= '0;
      pend_q        <= '0;
      allow_q       <= 1'b0;
      busy_q_w      <= 1'b0;
      exit_valid    <= 1'b0;
      exit_code     <= '0;
      con_out_valid <= 1'b0;
      con_out_byte  <= '0;
    end else begin
      if (to_en)    to_q     <= to_n;
      if (from_en)  from_q   <= from_n;
      if (pend_en)  pend_q   <= pend_n;
      if (allow_en) allow_q  <= allow_n;
      if (busy_en)  busy_q_w <= busy_n;
      exit_valid    <= ex_v_n;
      exit_code     <= code_n;
      con_out_valid <= co_v_n;
      con_out_byte  <= co_b_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel[0]) rdata = to_q[HALF_W-1:0];
    if (sel[1]) rdata = to_q[WORD_W-1:HALF_W];
    if (sel[2]) rdata = from_q[HALF_W-1:0];
    if (sel[3]) rdata = from_q[WORD_W-1:HALF_W];
  end

  AST_TOHOST_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    complete |=> (to_q == '0)); // R3
  AST_LO_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel[0] && to_q != '0) |=> ($stable(to_q) && !allow_q)); // R2
  AST_PARK_KEEPS_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && act == ACT_PARK && !con_in_valid) |=> $stable(from_q)); // R6
  AST_PUTC_REPLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    con_out_valid |-> (from_q[15:0] == {8'h01, con_out_byte})); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({exit_valid, con_out_valid})); // R4
  AST_BUSY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel[3]) |=> !busy); // R9
endmodule

// File: rtl/host_mailbox.sv
module host_mailbox
  import host_mailbox_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int TO_OFS   = 0,
  parameter int FROM_OFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              con_in_valid,
  input  logic [7:0]        con_in_byte,
  output logic              con_out_valid,
  output logic [7:0]        con_out_byte,
  output logic              exit_valid,
  output logic [46:0]       exit_code,
  output logic              host_busy
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [3:0]        sel;
  logic [WORD_W-1:0] cand_word;
  mbx_act_e          act;
  logic [PAY_W-1:0]  reply;
  logic [CODE_W-1:0] code;
  logic [7:0]        ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hmb_addr_dec #(.ADDR_W(ADDR_W), .TO_OFS(TO_OFS), .FROM_OFS(FROM_OFS)) u_addr (
    .addr (bus_addr),
    .sel  (sel)
  );

  hmb_cmd_dec u_cmd (
    .word  (cand_word),
    .act   (act),
    .reply (reply),
    .code  (code),
    .ch    (ch)
  );

  hmb_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr            (bus_wr),
    .wdata         (bus_wdata),
    .sel           (sel),
    .act           (act),
    .reply         (reply),
    .code          (code),
    .ch            (ch),
    .con_in_valid  (con_in_valid),
    .con_in_byte   (con_in_byte),
    .cand_word     (cand_word),
    .rdata         (bus_rdata),
    .exit_valid    (exit_valid),
    .exit_code     (exit_code),
    .con_out_valid (con_out_valid),
    .con_out_byte  (con_out_byte),
    .busy          (host_busy)
  );

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == 4'b0000) |-> (bus_rdata == 32'h0)); // R10
endmodule

// File: tb/tb_host_mailbox.sv
`timescale 1ns/1ps
module tb_host_mailbox;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        con_in_valid;
  logic [7:0]  con_in_byte;
  logic        con_out_valid;
  logic [7:0]  con_out_byte;
  logic        exit_valid;
  logic [46:0] exit_code;
  logic        host_busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  host_mailbox dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .con_in_valid(con_in_valid),
    .con_in_byte(con_in_byte), .con_out_valid(con_out_valid), .con_out_byte(con_out_byte),
    .exit_valid(exit_valid), .exit_code(exit_code), .host_busy(host_busy)
  );

  typedef struct packed {
    logic [63:0] word;
    logic [63:0] reply;
    logic        ex;
    logic [46:0] code;
    logic        co;
    logic [7:0]  ch;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{64'h0101_0000_0000_0041, 64'h0101_0000_0000_0141, 1'b0, 47'h0, 1'b1, 8'h41},
    '{64'h0000_0000_0000_0055, 64'h0000_0000_0000_0000, 1'b1, 47'h2A, 1'b0, 8'h00},
    '{64'h0000_0000_0000_0054, 64'h0000_0000_0000_0000, 1'b0, 47'h0, 1'b0, 8'h00},
    '{64'h0207_0000_0000_1234, 64'h0207_0000_0000_0000, 1'b0, 47'h0, 1'b0, 8'h00},
    '{64'h0105_0000_0000_00FF, 64'h0105_0000_0000_0000, 1'b0, 47'h0, 1'b0, 8'h00},
    '{64'h0101_ABCD_EF00_007E, 64'h0101_0000_0000_017E, 1'b0, 47'h0, 1'b1, 8'h7E},
    '{64'h0000_8000_0000_0003, 64'h0000_0000_0000_0000, 1'b1, 47'h4000_0000_0001, 1'b0, 8'h00}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic read64(input logic [4:0] base, output logic [63:0] v);
    logic [31:0] lo, hi;
    bus_read(base, lo);
    bus_read(base + 5'd4, hi);
    v = {hi, lo};
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    logic [31:0] r;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    con_in_valid = 1'b0; con_in_byte = '0;
    do_reset();

    // R1 reset state
    read64(5'd0, v); check(v == 64'h0, "R1 to-host", v, 64'h0);
    read64(5'd8, v); check(v == 64'h0, "R1 from-host", v, 64'h0);
    check({exit_valid, con_out_valid, host_busy} == 3'b000, "R1 outputs",
          {61'h0, exit_valid, con_out_valid, host_busy}, 64'h0);

    // R3 R4 R5 R8 vector table
    for (int i = 0; i < 7; i++) begin
      bus_write(5'd0, VECS[i].word[31:0]);
      bus_write(5'd4, VECS[i].word[63:32]);
      check(exit_valid == VECS[i].ex, "R4 exit strobe", {63'h0, exit_valid}, {63'h0, VECS[i].ex});
      if (VECS[i].ex)
        check(exit_code == VECS[i].code, "R4 exit code", {17'h0, exit_code}, {17'h0, VECS[i].code});
      check(con_out_valid == VECS[i].co, "R5 console strobe", {63'h0, con_out_valid}, {63'h0, VECS[i].co});
      if (VECS[i].co)
        check(con_out_byte == VECS[i].ch, "R5 console byte", {56'h0, con_out_byte}, {56'h0, VECS[i].ch});
      @(negedge clk);
      check(!exit_valid && !con_out_valid, "R4 one-cycle strobe",
            {62'h0, exit_valid, con_out_valid}, 64'h0);
      read64(5'd8, v); check(v == VECS[i].reply, "R8 R5 reply word", v, VECS[i].reply);
      read64(5'd0, v); check(v == 64'h0, "R3 to-host emptied", v, 64'h0);
    end

    // R7 input with no parked request: tag bits zero
    @(negedge clk); con_in_valid = 1'b1; con_in_byte = 8'h33;
    @(negedge clk); con_in_valid = 1'b0;
    read64(5'd8, v); check(v == 64'h0000_0000_0000_0133, "R7 input unparked", v, 64'h0000_0000_0000_0133);

    // R6 park then R7 input
    bus_write(5'd0, 32'h0000_DEAD);
    bus_write(5'd4, 32'h0100_0000);
    check(!exit_valid && !con_out_valid, "R6 no strobe", {62'h0, exit_valid, con_out_valid}, 64'h0);
    read64(5'd8, v); check(v == 64'h0000_0000_0000_0133, "R6 from-host unchanged", v, 64'h0000_0000_0000_0133);
    read64(5'd0, v); check(v == 64'h0, "R6 to-host emptied", v, 64'h0);
    @(negedge clk); con_in_valid = 1'b1; con_in_byte = 8'h5A;
    @(negedge clk); con_in_valid = 1'b0;
    read64(5'd8, v); check(v == 64'h0100_0000_0000_015A, "R7 input tagged", v, 64'h0100_0000_0000_015A);

    // R9 from-host direct writes
    bus_write(5'd8, 32'h1234_5678);
    check(host_busy == 1'b1, "R9 busy set", {63'h0, host_busy}, 64'h1);
    read64(5'd8, v); check(v == 64'h0000_0000_1234_5678, "R9 low replaces", v, 64'h0000_0000_1234_5678);
    bus_write(5'd12, 32'h0000_00F0);
    check(host_busy == 1'b0, "R9 busy cleared", {63'h0, host_busy}, 64'h0);
    read64(5'd8, v); check(v == 64'h0000_00F0_1234_5678, "R9 high ORs", v, 64'h0000_00F0_1234_5678);

    // R7 collision: input dropped when bus writes from-host in same cycle
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'd8; bus_wdata = 32'h0000_0777;
    con_in_valid = 1'b1; con_in_byte = 8'hC3;
    @(negedge clk);
    bus_wr = 1'b0; con_in_valid = 1'b0;
    read64(5'd8, v); check(v == 64'h0000_0000_0000_0777, "R7 collision drop", v, 64'h0000_0000_0000_0777);
    bus_write(5'd12, 32'h0);

    // R10 unmapped reads with non-zero registers
    bus_write(5'd0, 32'hCAFE_0001);
    bus_read(5'd2, r);  check(r == 32'h0, "R10 offset 2", {32'h0, r}, 64'h0);
    bus_read(5'd16, r); check(r == 32'h0, "R10 offset 16", {32'h0, r}, 64'h0);
    bus_read(5'd0, r);  check(r == 32'hCAFE_0001, "R10 offset 0", {32'h0, r}, 64'hCAFE_0001);

    // R2 rejected low write disarms the mailbox
    bus_write(5'd0, 32'h0000_9999);
    read64(5'd0, v); check(v == 64'h0000_0000_CAFE_0001, "R2 reject holds", v, 64'h0000_0000_CAFE_0001);
    bus_write(5'd4, 32'h0101_0000);
    check(!con_out_valid && !exit_valid, "R2 disarmed no action", {62'h0, exit_valid, con_out_valid}, 64'h0);
    read64(5'd0, v); check(v == 64'h0000_0000_CAFE_0001, "R2 high ignored", v, 64'h0000_0000_CAFE_0001);
    read64(5'd8, v); check(v == 64'h0000_0000_0000_0777, "R2 reply untouched", v, 64'h0000_0000_0000_0777);

    // R1 reset clears a loaded mailbox
    do_reset();
    read64(5'd0, v); check(v == 64'h0, "R1 re-reset to-host", v, 64'h0);
    read64(5'd8, v); check(v == 64'h0, "R1 re-reset from-host", v, 64'h0);

    finish_run();
  end
endmodule